// File: doc/BRIEF.md
# Serial-In Parallel-Out Shift and Storage Register

This block is a serial-to-parallel converter built from two register banks. A shift bank takes one bit per rising edge of its own clock and moves every held bit one place up. A separate storage bank copies the whole shift bank on a rising edge of a second clock, and only the storage bank drives the parallel outputs. Loading a new word therefore never disturbs the word being presented until the host chooses to commit it.

Each bank has its own asynchronous active-low clear, and a clear held low wins over any clock edge on that bank. The top shift stage is also brought out as a serial cascade output. Feeding that output into the serial input of a second instance builds a wider converter clocked by the same two clocks. When both clocks come from one signal, the storage bank captures the shift contents from before that edge, so it always trails the shift bank by one pulse.

Top module: `sipo_shift_store`

## Requirements
- R1: While `shift_clr_n` is low, every shift stage and `ser_out` are 0, whatever happens on `shift_clk`.
- R2: On a rising `shift_clk` edge with `shift_clr_n` high, `ser_in` enters shift bit 0 and shift bit i moves to bit i+1. Data is not inverted.
- R3: On a rising `store_clk` edge with `store_clr_n` high, `par_q` takes the shift bank contents, with `par_q[i]` equal to shift bit i.
- R4: Edges on `shift_clk` do not change `par_q`.
- R5: While `store_clr_n` is low, `par_q` is 0, whatever happens on `store_clk`.
- R6: The shift clear leaves `par_q` unchanged, and the storage clear leaves the shift bank (and so `ser_out`) unchanged.
- R7: A clear held low takes priority over a rising clock edge on the same bank at the same time.
- R8: When `shift_clk` and `store_clk` rise together, `par_q` takes the shift contents from before that edge.
- R9: `ser_out` equals shift bit WIDTH-1. Two instances chained through `ser_out` act as one 2*WIDTH-bit register, and the first bit shifted in reaches the top bit of the second instance after 2*WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift bank clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift bank |
| ser_in | input | 1 | Serial data into shift bit 0 |
| store_clk | input | 1 | Storage bank clock, rising edge |
| store_clr_n | input | 1 | Asynchronous active-low clear of the storage bank |
| par_q | output | WIDTH | Parallel outputs from the storage bank |
| ser_out | output | 1 | Cascade output, top shift stage |

## Verification
The bench sends a word through two chained instances and checks the parallel outputs of both. A wrong shift direction or a broken cascade would scramble that 16-bit word or leave the upper half unfilled. It fires shift pulses while the storage outputs stay frozen, which catches a storage bank wired straight to the shift bank. It also pulses each clock while its clear is held low; a design that let the edge win would show nonzero bits. Tied-clock pulses check that storage captures the value from before the edge, so a design that captured the new value would run one bit ahead.

// File: rtl/sipo_pkg.sv
// Shared parameter defaults for the serial-in parallel-out register.
package sipo_pkg;
    parameter int unsigned SIPO_WIDTH_DEF = 8;
endpackage

// File: rtl/sipo_shift_bank.sv
// Shift bank: one flop per bit, serial input at bit 0, moving upward.
// Assumes clr_n is asynchronous, active low, and dominant over clk.
module sipo_shift_bank #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_head
                // Purpose: bit 0 loads the serial input.
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n) q[i] <= 1'b0;
                    else        q[i] <= din;
                end
            end else begin : g_body
                // Purpose: bit i loads bit i-1.
                always_ff @(posedge clk or negedge clr_n) begin
                    if (!clr_n) q[i] <= 1'b0;
                    else        q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    // R2: bit 0 holds the previous edge's serial input
    a_r2_head_loads: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> q[0] == $past(din));
    // R2: the upper bits hold the previous lower bits
    a_r2_bits_move: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
    // R1: while the clear is low, an edge sees an empty bank
    a_r1_clear_empty: assert property (@(posedge clk) !clr_n |-> q == '0);
endmodule

// File: rtl/sipo_store_bank.sv
// Storage bank: copies its parallel input on each rising clk edge.
// Assumes clr_n is asynchronous, active low, and dominant over clk.
module sipo_store_bank #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Purpose: capture the shift bank contents, or clear them.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end

    // R3: outputs hold what the input was at the last edge
    a_r3_capture: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> q == $past(d));
    // R5: while the clear is low, an edge sees zero outputs
    a_r5_clear_zero: assert property (@(posedge clk) !clr_n |-> q == '0);
endmodule

// File: rtl/sipo_shift_store.sv
// Top: shift bank feeding a storage bank, with a cascade output.
// Assumes the two clocks are independent. When they are tied, storage
// takes the shift contents from before the shared edge.
module sipo_shift_store #(
    parameter int unsigned WIDTH = sipo_pkg::SIPO_WIDTH_DEF
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             ser_in,
    input  logic             store_clk,
    input  logic             store_clr_n,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);
    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;

    sipo_shift_bank #(.WIDTH(WIDTH)) u_shift (
        .clk   (shift_clk),
        .clr_n (shift_clr_n),
        .din   (ser_in),
        .q     (shift_q)
    );

    sipo_store_bank #(.WIDTH(WIDTH)) u_store (
        .clk   (store_clk),
        .clr_n (store_clr_n),
        .d     (shift_q),
        .q     (par_q)
    );

    // Purpose: bring the top shift stage out for chaining.
    assign ser_out = shift_q[TOP];

    // R9: the cascade output carries the stage below the top from the last edge
    a_r9_cascade: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        1'b1 |=> ser_out == $past(shift_q[TOP-1]));
endmodule

// File: tb/tb_sipo_shift_store.sv
module tb_sipo_shift_store;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz watchdog time base

    logic shift_clk = 0, store_clk = 0, shift_clr_n = 0, store_clr_n = 0, ser_in = 0;
    logic [W-1:0] par0, par1;
    logic so0, so1;

    sipo_shift_store #(.WIDTH(W)) dut (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(ser_in),
        .store_clk(store_clk), .store_clr_n(store_clr_n), .par_q(par0), .ser_out(so0));
    sipo_shift_store #(.WIDTH(W)) dut2 (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(so0),
        .store_clk(store_clk), .store_clr_n(store_clr_n), .par_q(par1), .ser_out(so1));

    // behavioural model of the 16-bit chain
    logic [2*W-1:0] m_sh = '0;
    logic [2*W-1:0] m_st = '0;
    int checks = 0, fails = 0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " par0"}, par0, m_st[W-1:0]);
        chk({tag, " par1"}, par1, m_st[2*W-1:W]);
        chk({tag, " so0"}, {7'd0, so0}, {7'd0, m_sh[W-1]});
        chk({tag, " so1"}, {7'd0, so1}, {7'd0, m_sh[2*W-1]});
    endtask

    function automatic void mdl_shift(input logic b);
        if (shift_clr_n) m_sh = {m_sh[2*W-2:0], b};
    endfunction

    function automatic void mdl_store();
        if (store_clr_n) m_st = m_sh;
    endfunction

    task automatic shift_pulse(input logic b, input string tag);
        ser_in = b; #4; shift_clk = 1; mdl_shift(b); #4; shift_clk = 0; #1; compare(tag);
    endtask

    task automatic store_pulse(input string tag);
        #4; store_clk = 1; mdl_store(); #4; store_clk = 0; #1; compare(tag);
    endtask

    task automatic both_pulse(input logic b, input string tag);
        ser_in = b; #4;
        shift_clk = 1; store_clk = 1; mdl_store(); mdl_shift(b);
        #4; shift_clk = 0; store_clk = 0; #1; compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] word;
        #10; compare("R1 R5 reset");
        shift_clr_n = 1; store_clr_n = 1; #2;
        // R2 R4: shift a byte in, outputs stay frozen
        word = 16'h00A5;
        for (int i = 7; i >= 0; i--) shift_pulse(word[i], "R2 R4 shift");
        store_pulse("R3 capture");
        // R9: 16-bit transfer through the chain
        word = 16'h3C96;
        for (int i = 15; i >= 0; i--) shift_pulse(word[i], "R9 chain");
        store_pulse("R9 chain store");
        chk("R9 full word", par1, word[15:8]);
        chk("R9 full word low", par0, word[7:0]);
        // R1 R6: shift clear leaves outputs alone
        #3; shift_clr_n = 0; m_sh = '0; #2; compare("R1 R6 shift clear");
        shift_pulse(1'b1, "R7 shift clear wins");
        shift_pulse(1'b1, "R7 shift clear wins");
        store_pulse("R1 cleared bank stored");
        shift_clr_n = 1; #2;
        for (int i = 0; i < 5; i++) shift_pulse(1'(i % 2 == 0), "R2 refill");
        store_pulse("R3 refill store");
        // R5 R6: storage clear leaves shift bank alone
        #3; store_clr_n = 0; m_st = '0; #2; compare("R5 R6 store clear");
        store_pulse("R7 store clear wins");
        store_clr_n = 1; #2;
        store_pulse("R3 after store clear");
        // R8: tied clocks, storage trails by one pulse
        for (int i = 0; i < 10; i++) both_pulse(1'(i % 3 == 0), "R8 tied");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule